// File: doc/BRIEF.md
# Dual-Width ALU with Flag Word

This block is an arithmetic logic unit with a 16-bit datapath. Each operation runs either on the whole word or on the low byte alone, as a width input selects. It computes add, add-with-carry, subtract, subtract-with-borrow, AND, OR, XOR and compare. Every operation that the caller issues rewrites six status flags from its outcome.

Three control flags (trap, interrupt, direction) sit beside the status flags in one 16-bit flag word. Only an explicit set/clear command changes them, and ALU traffic never touches them. The result and the flag word are registered. Both update on the clock edge that accepts an operation or a command.

Reset is asynchronous and active-low. Its release is synchronised inside the block, so the registers leave reset two clock edges after `rst_n` rises.

Top module: `alu_flagged`

## Requirements
- R1: With `wide`=1 the operation uses all 16 bits. With `wide`=0 only the low bytes of `a` and `b` are used, bits 15:8 of `result` are written as zero, and carry, zero, sign and overflow are taken from bit 7 and the low byte instead of bit 15 and the full word.
- R2: `op_code` encodes 0=add, 1=add-with-carry, 2=subtract, 3=subtract-with-borrow, 4=AND, 5=OR, 6=XOR, 7=compare. `result` is loaded on the clock edge where `op_valid`=1.
- R3: Add-with-carry adds the stored carry flag. Subtract-with-borrow also subtracts the stored carry flag, used as the borrow.
- R4: Carry (flag bit 0) is the carry out of, or the borrow into, the top bit of the selected width. Overflow (flag bit 11) is set on signed overflow of that width.
- R5: Zero (flag bit 6) is set when the selected width of the result is all zero. Sign (flag bit 7) is the top bit of the selected width.
- R6: Parity (flag bit 2) is set when bits 7:0 of the result hold an even number of ones, in either width.
- R7: Auxiliary carry (flag bit 4) is the carry out of bit 3 on add, or the borrow from bit 3 on subtract.
- R8: AND, OR and XOR clear carry, overflow and auxiliary carry.
- R9: Compare sets the flags exactly as subtract would and leaves `result` unchanged.
- R10: With `ctl_valid`=1, the flag picked by `ctl_sel` is loaded with `ctl_val`. The codes are 0=trap (bit 8), 1=interrupt (bit 9), 2=direction (bit 10), and 3 changes nothing. ALU operations never alter bits 10:8.
- R11: Flag bits 1, 3, 5 and 15:12 always read zero. While reset is asserted, `result` and `flags` are zero.
- R12: While `op_valid` and `ctl_valid` are both low, `result` and `flags` hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Perform the operation on this edge |
| op_code | input | 3 | Operation select |
| wide | input | 1 | 1 = 16-bit, 0 = 8-bit operation |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| ctl_valid | input | 1 | Control flag command strobe |
| ctl_sel | input | 2 | Control flag select |
| ctl_val | input | 1 | Value written to the selected control flag |
| result | output | 16 | Registered result |
| flags | output | 16 | Flag word |

## Verification
The bench builds the block with its default parameters: a 16-bit datapath whose narrow mode is the low byte, and a 16-bit flag word. This brings both carry sources within reach: the carry out of bit 7 in byte mode and out of bit 15 in word mode. The bench drives the same operands in both widths to show that flags differ when only the width changes. It also sets carry up beforehand through an ordinary add, so that add-with-carry and subtract-with-borrow meet both values of the stored flag. Control-flag commands are interleaved with ALU operations, so that every status update is checked against the control bits that must survive it.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    CTL_TRAP = 2'd0,
    CTL_INTR = 2'd1,
    CTL_DIR  = 2'd2,
    CTL_NONE = 2'd3
  } ctl_sel_e;

  // flag word bit positions
  localparam int FLG_C = 0;
  localparam int FLG_P = 2;
  localparam int FLG_A = 4;
  localparam int FLG_Z = 6;
  localparam int FLG_S = 7;
  localparam int FLG_T = 8;
  localparam int FLG_I = 9;
  localparam int FLG_D = 10;
  localparam int FLG_O = 11;

  typedef struct packed {
    logic o;
    logic s;
    logic z;
    logic a;
    logic p;
    logic c;
  } status_t;

  typedef struct packed {
    logic d;
    logic i;
    logic t;
  } ctl_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         wide,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cf,
  output logic         af,
  output logic         of
);
  localparam int AUX_BIT = 4;

  logic [W-1:0] b_eff;
  logic         cin_eff;
  logic [W:0]   total;
  logic         c_aux, c_nw, c_nm, c_w, c_wm;
  logic         c_out, c_msb;

  always_comb begin
    b_eff   = sub ? ~b : b;
    cin_eff = sub ? ~cin : cin;
    total   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
    sum     = total[W-1:0];
    // carry into bit k recovered as sum ^ a ^ b
    c_aux   = total[AUX_BIT] ^ a[AUX_BIT] ^ b_eff[AUX_BIT];
    c_nw    = total[NW] ^ a[NW] ^ b_eff[NW];
    c_nm    = total[NW-1] ^ a[NW-1] ^ b_eff[NW-1];
    c_w     = total[W];
    c_wm    = total[W-1] ^ a[W-1] ^ b_eff[W-1];
    c_out   = wide ? c_w : c_nw;
    c_msb   = wide ? c_wm : c_nm;
    cf      = c_out ^ sub;
    af      = c_aux ^ sub;
    of      = c_out ^ c_msb;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (fn)
      2'd0:    res = a & b;
      2'd1:    res = a | b;
      2'd2:    res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_status.sv
module alu_status #(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic [W-1:0] res,
  input  logic         wide,
  output logic         zf,
  output logic         sf,
  output logic         pf
);
  localparam int PAR_W = 8;

  always_comb begin
    zf = wide ? (res == '0) : (res[NW-1:0] == '0);
    sf = wide ? res[W-1] : res[NW-1];
    pf = ~^res[PAR_W-1:0];
  end
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
  import alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic              wide,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              ctl_valid,
  input  logic [1:0]        ctl_sel,
  input  logic              ctl_val,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  localparam int NARROW_W = DATA_W / 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  alu_op_e  op;
  ctl_sel_e csel;
  logic     is_logic, is_sub, use_cf, cin;

  status_t  st_q, st_d;
  ctl_t     ctl_q, ctl_d;
  logic     st_en, ctl_en, res_en;
  logic [DATA_W-1:0] res_q, res_d;

  logic [DATA_W-1:0] sum, lres, raw;
  logic              a_cf, a_af, a_of;
  logic              zf, sf, pf;

  always_comb begin
    op       = alu_op_e'(op_code);
    csel     = ctl_sel_e'(ctl_sel);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    use_cf   = (op == OP_ADC) || (op == OP_SBB);
    cin      = use_cf & st_q.c;
  end

  alu_arith #(.W(DATA_W), .NW(NARROW_W)) i_arith (
    .a    (a),
    .b    (b),
    .wide (wide),
    .sub  (is_sub),
    .cin  (cin),
    .sum  (sum),
    .cf   (a_cf),
    .af   (a_af),
    .of   (a_of)
  );

  alu_logic #(.W(DATA_W)) i_logic (
    .a   (a),
    .b   (b),
    .fn  (op_code[1:0]),
    .res (lres)
  );

  // width-masked raw result feeds both the flag logic and the register
  always_comb begin
    raw = is_logic ? lres : sum;
    if (!wide) raw = {{(DATA_W-NARROW_W){1'b0}}, raw[NARROW_W-1:0]};
  end

  alu_status #(.W(DATA_W), .NW(NARROW_W)) i_status (
    .res  (raw),
    .wide (wide),
    .zf   (zf),
    .sf   (sf),
    .pf   (pf)
  );

  // next-state
  always_comb begin
    st_en   = op_valid;
    res_en  = op_valid && (op != OP_CMP);
    ctl_en  = ctl_valid && (csel != CTL_NONE);

    st_d.c  = is_logic ? 1'b0 : a_cf;
    st_d.a  = is_logic ? 1'b0 : a_af;
    st_d.o  = is_logic ? 1'b0 : a_of;
    st_d.z  = zf;
    st_d.s  = sf;
    st_d.p  = pf;

    res_d   = raw;

    ctl_d   = ctl_q;
    unique case (csel)
      CTL_TRAP: ctl_d.t = ctl_val;
      CTL_INTR: ctl_d.i = ctl_val;
      CTL_DIR:  ctl_d.d = ctl_val;
      default:  ctl_d   = ctl_q;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q  <= '0;
      ctl_q <= '0;
      res_q <= '0;
    end else begin
      if (st_en)  st_q  <= st_d;
      if (ctl_en) ctl_q <= ctl_d;
      if (res_en) res_q <= res_d;
    end
  end

  always_comb begin
    result        = res_q;
    flags         = '0;
    flags[FLG_C]  = st_q.c;
    flags[FLG_P]  = st_q.p;
    flags[FLG_A]  = st_q.a;
    flags[FLG_Z]  = st_q.z;
    flags[FLG_S]  = st_q.s;
    flags[FLG_T]  = ctl_q.t;
    flags[FLG_I]  = ctl_q.i;
    flags[FLG_D]  = ctl_q.d;
    flags[FLG_O]  = st_q.o;
  end
endmodule

// File: rtl/alu_flagged_chk.sv
module alu_flagged_chk #(
  parameter int DATA_W = 16,
  parameter int FLAG_W = 16
) (
  input logic              clk,
  input logic              rst_q,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              wide,
  input logic              ctl_valid,
  input logic [1:0]        ctl_sel,
  input logic              ctl_val,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] flags
);
  localparam logic [FLAG_W-1:0] USED = FLAG_W'(12'hFD5);

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (flags & ~USED) == '0); // R11

  AST_CTL_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && !ctl_valid) |=> (flags[10:8] == $past(flags[10:8]))); // R10

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_q)
    (ctl_valid && ctl_sel == 2'd2) |=> (flags[10] == $past(ctl_val))); // R10

  AST_CMP_KEEPS: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == 3'd7) |=> $stable(result)); // R9

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code[2] && op_code != 3'd7)
      |=> (!flags[0] && !flags[4] && !flags[11])); // R8

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && !wide && op_code != 3'd7) |=> (result[DATA_W-1:8] == '0)); // R1

  AST_PARITY_LOW: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code != 3'd7) |=> (flags[2] == ~^result[7:0])); // R6

  AST_ZERO_WIDE: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && wide && op_code != 3'd7) |=> (flags[6] == (result == '0))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (!op_valid && !ctl_valid) |=> ($stable(flags) && $stable(result))); // R12
endmodule

bind alu_flagged alu_flagged_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) i_chk (
  .clk       (clk),
  .rst_q     (rst_sync_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .wide      (wide),
  .ctl_valid (ctl_valid),
  .ctl_sel   (ctl_sel),
  .ctl_val   (ctl_val),
  .result    (result),
  .flags     (flags)
);

// File: tb/test_alu_flagged.sv
module test_alu_flagged;
  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic        wide;
  logic [15:0] a, b;
  logic        ctl_valid;
  logic [1:0]  ctl_sel;
  logic        ctl_val;
  logic [15:0] result;
  logic [15:0] flags;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  alu_flagged i_alu_flagged (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .wide(wide), .a(a), .b(b), .ctl_valid(ctl_valid), .ctl_sel(ctl_sel),
    .ctl_val(ctl_val), .result(result), .flags(flags)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [2:0]  op;
    logic        wd;
    logic        cfin;
    logic [15:0] x;
    logic [15:0] y;
    logic [15:0] res;
    logic [15:0] flg;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b1, 1'b0, 16'h1234, 16'h4321, 16'h5555, 16'h0004},
    '{3'd0, 1'b1, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 16'h0055},
    '{3'd0, 1'b1, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 16'h0894},
    '{3'd0, 1'b0, 1'b0, 16'h12FF, 16'h3401, 16'h0000, 16'h0055},
    '{3'd0, 1'b0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 16'h0890},
    '{3'd2, 1'b1, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 16'h0095},
    '{3'd2, 1'b1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 16'h0814},
    '{3'd2, 1'b0, 1'b0, 16'hAB50, 16'h1150, 16'h0000, 16'h0044},
    '{3'd4, 1'b1, 1'b0, 16'hF0F0, 16'h0FF0, 16'h00F0, 16'h0004},
    '{3'd5, 1'b0, 1'b0, 16'hFF00, 16'h0081, 16'h0081, 16'h0084},
    '{3'd6, 1'b1, 1'b0, 16'hA5A5, 16'hA5A5, 16'h0000, 16'h0044},
    '{3'd6, 1'b1, 1'b0, 16'h8001, 16'h0000, 16'h8001, 16'h0080},
    '{3'd1, 1'b0, 1'b1, 16'h0010, 16'h000F, 16'h0020, 16'h0010},
    '{3'd3, 1'b1, 1'b1, 16'h0005, 16'h0004, 16'h0000, 16'h0044},
    '{3'd3, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'hFFFF, 16'h0095},
    '{3'd1, 1'b1, 1'b0, 16'h0001, 16'h0001, 16'h0002, 16'h0000}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic w, input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; wide = w; a = x; b = y;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_ctl(input logic [1:0] sel, input logic val);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_sel = sel; ctl_val = val;
    @(negedge clk);
    ctl_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; wide = 1'b1;
    a = '0; b = '0; ctl_valid = 1'b0; ctl_sel = '0; ctl_val = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R11 reset flags", flags, 16'h0000);
    check("R11 reset result", result, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      // set the stored carry to the vector's carry-in with a plain add
      do_op(3'd0, 1'b1, VECS[i].cfin ? 16'hFFFF : 16'h0000, VECS[i].cfin ? 16'h0001 : 16'h0000);
      do_op(VECS[i].op, VECS[i].wd, VECS[i].x, VECS[i].y);
      check($sformatf("R2 result vec %0d", i), result, VECS[i].res);
      check($sformatf("R4 R5 R6 R7 flags vec %0d", i), flags, VECS[i].flg);
    end

    // R10 control flags
    do_ctl(2'd0, 1'b1);
    check("R10 set trap", flags, 16'h0100);
    do_ctl(2'd2, 1'b1);
    check("R10 set direction", flags, 16'h0500);
    do_op(3'd0, 1'b1, 16'hFFFF, 16'h0001);
    check("R10 ALU op keeps control", flags, 16'h0555);
    do_ctl(2'd0, 1'b0);
    check("R10 clear trap", flags, 16'h0455);
    do_ctl(2'd1, 1'b1);
    check("R10 set interrupt", flags, 16'h0655);
    do_ctl(2'd3, 1'b1);
    check("R10 select 3 ignored", flags, 16'h0655);

    // R9 compare
    do_op(3'd0, 1'b1, 16'h1111, 16'h2222);
    check("R9 pre-compare result", result, 16'h3333);
    do_op(3'd7, 1'b1, 16'h0003, 16'h0005);
    check("R9 compare keeps result", result, 16'h3333);
    check("R9 compare flags", flags, 16'h0691);

    // R12 idle
    @(negedge clk);
    op_code = 3'd0; wide = 1'b1; a = 16'hFFFF; b = 16'h0001;
    repeat (2) @(negedge clk);
    check("R12 idle result", result, 16'h3333);
    check("R12 idle flags", flags, 16'h0691);

    // R8 logic clears carry (carry set by the compare above)
    do_op(3'd4, 1'b1, 16'hFFFF, 16'hFFFF);
    check("R8 AND result", result, 16'hFFFF);
    check("R8 AND flags", flags, 16'h0684);

    // R3 add-with-carry using a carry from a byte add
    do_op(3'd0, 1'b0, 16'h00FF, 16'h0001);
    check("R3 byte carry set", flags, 16'h0655);
    do_op(3'd1, 1'b0, 16'h0001, 16'h0001);
    check("R3 adc result", result, 16'h0003);
    check("R3 adc flags", flags, 16'h0604);

    // R1 same operands, two widths
    do_op(3'd0, 1'b0, 16'h0180, 16'h0180);
    check("R1 byte result", result, 16'h0000);
    check("R1 byte flags", flags, 16'h0E45);
    do_op(3'd0, 1'b1, 16'h0180, 16'h0180);
    check("R1 word result", result, 16'h0300);
    check("R1 word flags", flags, 16'h0604);

    // R11 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 async reset flags", flags, 16'h0000);
    check("R11 async reset result", result, 16'h0000);
    repeat (2) @(negedge clk);

    finish_run();
  end
endmodule